// File: doc/BRIEF.md
# Sign-Select Dot-Product Engine

This block is a streaming dot-product engine for low-precision neural network layers. Every clock cycle it can take one beat of sixteen signed 16-bit activations together with sixteen 2-bit weight codes. Each weight code makes its lane pass the activation, its negation or zero. No multiplier is used for this: a small selector in each lane does the work. A registered adder tree reduces the sixteen lane terms to one partial sum. An accumulator adds the partial sums of consecutive beats until a beat flagged as the final one arrives.

Only one multiply exists in the block. The per-layer scale supplied with the final beat is multiplied into the completed sum once, and the result is presented for one cycle at a fixed latency. A static mode input chooses how the codes are read. In binary mode only bit 0 of each lane code matters. In ternary mode the full 2-bit code selects +1, -1 or 0.

The engine never stalls. After reset it accepts a beat in every cycle in which a beat is offered, so back-to-back dot products complete at the same rate as they are fed.

Top module: `signsel_dot_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `outValid` is low. `inReady` is low while reset is asserted.
- R2: When `ternMode`=0, lane i contributes +a when `inWgt[2i]`=1 and -a when `inWgt[2i]`=0, where a is the signed value `inAct[16i+15:16i]`. Bit `inWgt[2i+1]` has no effect. The value -(-32768) is produced exactly as +32768.
- R3: When `ternMode`=1, lane i's code `inWgt[2i+1:2i]` selects +a for 2'b01, -a for 2'b11, and 0 for both 2'b00 and 2'b10.
- R4: The beat sums of all accepted beats since the previous final beat (or since reset) are added together. The beat accepted after a final beat starts a new sum from zero.
- R5: `outResult` equals the signed product of the accumulated sum and the signed 16-bit `inScale` value, so a zero scale gives a zero result.
- R6: `outValid` is a single-cycle pulse. It rises exactly 6 clock edges after the edge that accepts a final beat (`inLast`=1), and there is exactly one pulse per final beat.
- R7: From the first cycle after reset release, `inReady` stays high. A beat is accepted every cycle that `inValid` is high, so single-beat products issued back to back yield one result per cycle.
- R8: A dot product of up to 256 beats with full-scale activations and the extreme scale -32768 gives the exact result, with no wrap-around.
- R9: Cycles with `inValid` low change nothing, whatever `inAct`, `inWgt`, `inLast` and `inScale` carry in those cycles.
- R10: Only the `inScale` value on the final beat is used. Values present on earlier beats have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ternMode | input | 1 | 1 = ternary code reading, 0 = binary; changed only while idle |
| inValid | input | 1 | A beat is offered |
| inReady | output | 1 | The engine can accept a beat |
| inLast | input | 1 | The offered beat is the final one of a dot product |
| inAct | input | 256 | Sixteen signed 16-bit activations, lane i at bits 16i+15:16i |
| inWgt | input | 32 | Sixteen 2-bit weight codes, lane i at bits 2i+1:2i |
| inScale | input | 16 | Signed per-layer scale, taken from the final beat |
| outValid | output | 1 | One-cycle pulse marking a finished result |
| outResult | output | 45 | Signed scaled dot product |

## Verification
The accumulator can restart for a new dot product in the same cycle that the output stage multiplies the completed sum of the previous one. A last beat followed directly by the next product's first beat leaves the old sum and the new first partial sum sharing that edge. The bench provokes this with runs of single-beat products and of two-beat products issued with no idle cycle between them. Each product carries its own random scale. Every result is compared with a model accumulated independently in the bench, and the bench also checks that each result arrives exactly six cycles after its final beat. Any leakage of the new partial sum, or of the new scale, into the old result then shows up as a mismatched value.

// File: rtl/sdot_pkg.sv
`timescale 1ns/1ps
package sdot_pkg;

  // Ternary weight codes; every other code reads as zero.
  localparam logic [1:0] CODE_POS = 2'b01;
  localparam logic [1:0] CODE_NEG = 2'b11;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic beatTake;   // capture lane terms of an accepted beat
    logic accStep;    // tree output holds a valid beat sum
    logic accFresh;   // that beat opens a new dot product
    logic accClose;   // that beat closes the dot product
    logic outLoad;    // multiply the finished sum by its scale
  } sdotStrobe_t;

endpackage

// File: rtl/sdot_lane.sv
`timescale 1ns/1ps
module sdot_lane
  import sdot_pkg::*;
#(
  parameter int ACT_W = 16
) (
  input  logic signed [ACT_W-1:0] act,
  input  logic        [1:0]       code,
  input  logic                    ternMode,
  output logic signed [ACT_W:0]   term
);

  logic signed [ACT_W:0] posTerm;
  logic signed [ACT_W:0] negTerm;

  // One extra bit so the negated most-negative value is exact.
  assign posTerm = (ACT_W+1)'(act);
  assign negTerm = -posTerm;

  always_comb begin
    if (ternMode) begin
      unique case (code)
        CODE_POS: term = posTerm;
        CODE_NEG: term = negTerm;
        default:  term = '0;
      endcase
    end else begin
      term = code[0] ? posTerm : negTerm;
    end
  end

endmodule

// File: rtl/sdot_ctrl.sv
`timescale 1ns/1ps
module sdot_ctrl
  import sdot_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        inLast,
  output logic        inReady,
  output sdotStrobe_t strobe,
  output logic        outValid
);

  localparam int LEVELS = $clog2(LANES);

  logic              readyQ;
  logic              openQ;      // a dot product is in progress
  logic [LEVELS:0]   validPipe;  // beat valid, lane stage up to tree top
  logic [LEVELS:0]   freshPipe;
  logic [LEVELS:0]   lastPipe;
  logic              doneQ;
  logic              outValidQ;
  logic              take;

  assign take = inValid & readyQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      readyQ    <= 1'b0;
      openQ     <= 1'b0;
      validPipe <= '0;
      freshPipe <= '0;
      lastPipe  <= '0;
      doneQ     <= 1'b0;
      outValidQ <= 1'b0;
    end else begin
      readyQ    <= 1'b1;
      if (take) openQ <= !inLast;
      validPipe <= {validPipe[LEVELS-1:0], take};
      freshPipe <= {freshPipe[LEVELS-1:0], take & !openQ};
      lastPipe  <= {lastPipe[LEVELS-1:0],  take & inLast};
      doneQ     <= lastPipe[LEVELS];
      outValidQ <= doneQ;
    end
  end

  always_comb begin
    strobe.beatTake = take;
    strobe.accStep  = validPipe[LEVELS];
    strobe.accFresh = freshPipe[LEVELS];
    strobe.accClose = lastPipe[LEVELS];
    strobe.outLoad  = doneQ;
  end

  assign inReady  = readyQ;
  assign outValid = outValidQ;

endmodule

// File: rtl/sdot_datapath.sv
`timescale 1ns/1ps
module sdot_datapath
  import sdot_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int ACT_W     = 16,
  parameter int SCALE_W   = 16,
  parameter int MAX_BEATS = 256,
  localparam int LEVELS   = $clog2(LANES),
  localparam int TREE_W   = ACT_W + 1 + LEVELS,
  localparam int ACC_W    = TREE_W + $clog2(MAX_BEATS),
  localparam int RES_W    = ACC_W + SCALE_W
) (
  input  logic                       clk,
  input  logic                       ternMode,
  input  logic [LANES*ACT_W-1:0]     inAct,
  input  logic [2*LANES-1:0]         inWgt,
  input  logic signed [SCALE_W-1:0]  inScale,
  input  sdotStrobe_t                strobe,
  output logic signed [RES_W-1:0]    outResult
);

  logic signed [ACT_W:0]   laneTerm [LANES];
  logic signed [ACT_W:0]   laneQ    [LANES];
  logic signed [SCALE_W-1:0] scalePipe [LEVELS+1];
  logic signed [SCALE_W-1:0] scaleHold;
  logic signed [TREE_W-1:0]  treeSum;
  logic signed [ACC_W-1:0]   accQ;
  logic signed [ACC_W-1:0]   accNext;
  logic signed [RES_W-1:0]   resultQ;

  // Sign-select lanes
  for (genvar i = 0; i < LANES; i++) begin : laneG
    sdot_lane #(.ACT_W(ACT_W)) uLane (
      .act      (inAct[i*ACT_W +: ACT_W]),
      .code     (inWgt[2*i +: 2]),
      .ternMode (ternMode),
      .term     (laneTerm[i])
    );
  end

  always_ff @(posedge clk) begin
    if (strobe.beatTake) begin
      for (int i = 0; i < LANES; i++) laneQ[i] <= laneTerm[i];
    end
  end

  // Registered adder tree, one register per level
  for (genvar l = 0; l < LEVELS; l++) begin : lvlG
    localparam int NODES = LANES >> (l + 1);
    logic signed [TREE_W-1:0] node [NODES];
    for (genvar n = 0; n < NODES; n++) begin : addG
      if (l == 0) begin : leafG
        always_ff @(posedge clk)
          node[n] <= TREE_W'(laneQ[2*n]) + TREE_W'(laneQ[2*n+1]);
      end else begin : innerG
        always_ff @(posedge clk)
          node[n] <= lvlG[l-1].node[2*n] + lvlG[l-1].node[2*n+1];
      end
    end
  end

  assign treeSum = lvlG[LEVELS-1].node[0];

  // Scale rides alongside the beat until the accumulator stage
  always_ff @(posedge clk) begin
    scalePipe[0] <= inScale;
    for (int k = 1; k <= LEVELS; k++) scalePipe[k] <= scalePipe[k-1];
  end

  // Accumulator
  assign accNext = (strobe.accFresh ? '0 : accQ) + ACC_W'(treeSum);

  always_ff @(posedge clk) begin
    if (strobe.accStep)  accQ      <= accNext;
    if (strobe.accClose) scaleHold <= scalePipe[LEVELS];
  end

  // Single shared-scale multiply
  always_ff @(posedge clk) begin
    if (strobe.outLoad) resultQ <= RES_W'(accQ) * RES_W'(scaleHold);
  end

  assign outResult = resultQ;

endmodule

// File: rtl/signsel_dot_engine.sv
`timescale 1ns/1ps
module signsel_dot_engine
  import sdot_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int ACT_W     = 16,
  parameter int SCALE_W   = 16,
  parameter int MAX_BEATS = 256,
  localparam int LEVELS   = $clog2(LANES),
  localparam int RES_W    = ACT_W + 1 + LEVELS + $clog2(MAX_BEATS) + SCALE_W,
  localparam int LATENCY  = LEVELS + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ternMode,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic                      inLast,
  input  logic [LANES*ACT_W-1:0]    inAct,
  input  logic [2*LANES-1:0]        inWgt,
  input  logic signed [SCALE_W-1:0] inScale,
  output logic                      outValid,
  output logic signed [RES_W-1:0]   outResult
);

  sdotStrobe_t strobe;

  sdot_ctrl #(.LANES(LANES)) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .inLast   (inLast),
    .inReady  (inReady),
    .strobe   (strobe),
    .outValid (outValid)
  );

  sdot_datapath #(
    .LANES(LANES), .ACT_W(ACT_W), .SCALE_W(SCALE_W), .MAX_BEATS(MAX_BEATS)
  ) uDp (
    .clk       (clk),
    .ternMode  (ternMode),
    .inAct     (inAct),
    .inWgt     (inWgt),
    .inScale   (inScale),
    .strobe    (strobe),
    .outResult (outResult)
  );

endmodule

// File: rtl/sdot_checker.sv
`timescale 1ns/1ps
module sdot_checker #(
  parameter int SCALE_W   = 16,
  parameter int RES_W     = 45,
  parameter int LATENCY   = 6,
  parameter int MAX_BEATS = 256,
  localparam int CNT_W    = $clog2(MAX_BEATS) + 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      inValid,
  input logic                      inReady,
  input logic                      inLast,
  input logic signed [SCALE_W-1:0] inScale,
  input logic                      outValid,
  input logic signed [RES_W-1:0]   outResult
);

  logic                      take;
  logic [LATENCY:0]          closePipe;
  logic signed [SCALE_W-1:0] scaleTrail [LATENCY+1];
  logic [CNT_W-1:0]          beatCnt;

  assign take = inValid & inReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      closePipe <= '0;
      beatCnt   <= '0;
    end else begin
      closePipe <= {closePipe[LATENCY-1:0], take & inLast};
      if (take) beatCnt <= inLast ? '0 : beatCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    scaleTrail[0] <= inScale;
    for (int k = 1; k <= LATENCY; k++) scaleTrail[k] <= scaleTrail[k-1];
  end

  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> inReady); // R7

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    outValid == closePipe[LATENCY]); // R6

  AST_ZERO_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && scaleTrail[LATENCY] == '0) |-> (outResult == '0)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (beatCnt < CNT_W'(MAX_BEATS))); // R8

endmodule

bind signsel_dot_engine sdot_checker #(
  .SCALE_W(SCALE_W), .RES_W(RES_W), .LATENCY(LATENCY), .MAX_BEATS(MAX_BEATS)
) uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inValid   (inValid),
  .inReady   (inReady),
  .inLast    (inLast),
  .inScale   (inScale),
  .outValid  (outValid),
  .outResult (outResult)
);

// File: tb/sim_signsel_dot_engine.sv
`timescale 1ns/1ps
module sim_signsel_dot_engine;

  localparam int LANES   = 16;
  localparam int ACT_W   = 16;
  localparam int SCALE_W = 16;
  localparam int RES_W   = 45;
  localparam int LATENCY = 6;
  localparam int CLK_NS  = 20;

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic                      ternMode = 1'b0;
  logic                      inValid = 1'b0;
  logic                      inReady;
  logic                      inLast = 1'b0;
  logic [LANES*ACT_W-1:0]    inAct = '0;
  logic [2*LANES-1:0]        inWgt = '0;
  logic signed [SCALE_W-1:0] inScale = '0;
  logic                      outValid;
  logic signed [RES_W-1:0]   outResult;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;
  longint expAcc = 0;
  longint expQ[$];
  int     cycQ[$];
  string  tagQ[$];

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  signsel_dot_engine u0 (
    .clk(clk), .rst_n(rst_n), .ternMode(ternMode), .inValid(inValid),
    .inReady(inReady), .inLast(inLast), .inAct(inAct), .inWgt(inWgt),
    .inScale(inScale), .outValid(outValid), .outResult(outResult)
  );

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic longint beatSum(input logic [LANES*ACT_W-1:0] a,
                                     input logic [2*LANES-1:0] w, input bit tern);
    longint s;
    s = 0;
    for (int i = 0; i < LANES; i++) begin
      longint v;
      logic [1:0] c;
      v = longint'($signed(a[i*ACT_W +: ACT_W]));
      c = w[2*i +: 2];
      if (tern) begin
        if (c == 2'b01) s += v;
        else if (c == 2'b11) s -= v;
      end else begin
        s += c[0] ? v : -v;
      end
    end
    return s;
  endfunction

  function automatic logic [LANES*ACT_W-1:0] randActs();
    logic [LANES*ACT_W-1:0] a;
    for (int i = 0; i < LANES; i++) a[i*ACT_W +: ACT_W] = 16'($urandom);
    return a;
  endfunction

  task automatic sendBeat(input logic [LANES*ACT_W-1:0] a, input logic [2*LANES-1:0] w,
                          input bit last, input logic signed [SCALE_W-1:0] sc,
                          input string tag);
    @(negedge clk);
    inValid = 1'b1; inAct = a; inWgt = w; inLast = last; inScale = sc;
    expAcc += beatSum(a, w, ternMode);
    @(posedge clk); #1;
    if (last) begin
      expQ.push_back(expAcc * longint'(sc));
      cycQ.push_back(cyc);
      tagQ.push_back(tag);
      expAcc = 0;
    end
  endtask

  // Idle cycles carry garbage that must be ignored (R9)
  task automatic idle(input int n);
    @(negedge clk);
    inValid = 1'b0; inAct = randActs(); inWgt = 32'($urandom);
    inLast = 1'b1; inScale = 16'($urandom);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R6 unexpected result", longint'(outResult), 0);
      end else begin
        longint e;
        int c;
        string t;
        e = expQ.pop_front(); c = cycQ.pop_front(); t = tagQ.pop_front();
        chk(longint'(outResult) == e, t, longint'(outResult), e);
        chk(cyc - c == LATENCY, "R6 latency", longint'(cyc - c), LATENCY);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    failures++;
    $display("FAIL R6 watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [LANES*ACT_W-1:0] a;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outValid == 1'b0, "R1 outValid in reset", longint'(outValid), 0);
    chk(inReady == 1'b0, "R1 inReady in reset", longint'(inReady), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R1 outValid after reset", longint'(outValid), 0);
    chk(inReady == 1'b1, "R7 inReady after reset", longint'(inReady), 1);

    // R2: binary mode, bit 1 of each code is random and ignored
    ternMode = 1'b0;
    sendBeat(randActs(), 32'($urandom), 1'b1, 16'sd1, "R2 binary scale 1");
    sendBeat(randActs(), 32'($urandom), 1'b1, 16'sd3, "R2 binary scale 3");
    sendBeat(randActs(), 32'hFFFF_0000, 1'b1, -16'sd7, "R2 binary split");
    for (int i = 0; i < LANES; i++) a[i*ACT_W +: ACT_W] = 16'h8000;
    sendBeat(a, 32'hAAAA_AAAA, 1'b1, 16'sd1, "R2 negate most negative");
    idle(2);

    // R4 R9 R10: multi-beat with gaps, early scales ignored
    sendBeat(randActs(), 32'($urandom), 1'b0, 16'sd100, "R4 beat");
    idle(3);
    sendBeat(randActs(), 32'($urandom), 1'b0, 16'sd100, "R9 beat");
    idle(1);
    sendBeat(randActs(), 32'($urandom), 1'b1, 16'sd5, "R10 last-beat scale");
    idle(LATENCY + 4);

    // R3: ternary codes 00,01,10,11 across lanes
    ternMode = 1'b1;
    idle(2);
    sendBeat(randActs(), 32'hE4E4_E4E4, 1'b1, -16'sd2, "R3 mixed codes");
    sendBeat(randActs(), 32'hAAAA_AAAA, 1'b1, 16'sd9, "R3 code 10 is zero");
    sendBeat(randActs(), 32'h5555_5555, 1'b1, 16'sd1, "R3 all plus");
    sendBeat(randActs(), 32'hFFFF_FFFF, 1'b1, 16'sd1, "R3 all minus");
    idle(2);

    // R7 R4: back-to-back single-beat products, result per cycle
    for (int k = 0; k < 8; k++)
      sendBeat(randActs(), 32'($urandom), 1'b1, 16'($urandom), "R7 back-to-back");
    // R4: two-beat products back to back, restart at each first beat
    for (int k = 0; k < 4; k++) begin
      sendBeat(randActs(), 32'($urandom), 1'b0, 16'($urandom), "R4 first");
      sendBeat(randActs(), 32'($urandom), 1'b1, 16'($urandom), "R4 restart");
    end
    idle(2);

    // R5: zero scale
    sendBeat(randActs(), 32'h5555_5555, 1'b0, 16'sd4, "R5 beat");
    sendBeat(randActs(), 32'h5555_5555, 1'b1, 16'sd0, "R5 zero scale");
    sendBeat(randActs(), 32'($urandom), 1'b1, -16'sd1, "R5 negative scale");
    idle(2);

    // R8: 256 full-scale beats, extreme scale
    for (int i = 0; i < LANES; i++) a[i*ACT_W +: ACT_W] = 16'h8000;
    for (int k = 0; k < 256; k++)
      sendBeat(a, 32'hFFFF_FFFF, k == 255, 16'sh8000, "R8 extreme accumulation");
    idle(LATENCY + 4);

    chk(expQ.size() == 0, "R6 results outstanding", longint'(expQ.size()), 0);
    chk(outValid == 1'b0, "R9 no output while idle", longint'(outValid), 0);
    summary();
  end

endmodule